// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a load/store unit and a memory bus that only accepts naturally aligned transfers. It takes one request at a time: a byte, halfword, word or doubleword access, with a 32-bit start address, write data and a select bit that picks the code-side or the system-side address rule. Each request that is not naturally aligned is broken into a sequence of aligned bus beats. Each beat carries its own address, size code and 4-bit byte-lane mask. On a store, every byte is steered onto the lane its address selects. On a load, the bytes returned by each beat are gathered into a right-justified, zero-extended result. When the last beat has completed, that result is presented with a single-cycle done pulse.

The two port rules differ only in how the address moves from one beat to the next. On the code side it wraps inside the 512 MB window that holds the first byte. On the system side it is a plain 32-bit increment, so it carries into the next region or rolls over past the top of memory. A crossing into a bit-band alias area gets no special treatment. The block faults, and issues no beat, on a doubleword that is not word aligned and on any misaligned request that starts in the private peripheral window.

The controller has four states. ST_IDLE accepts a request and moves to ST_FAULT when the request is illegal, or to ST_BEAT otherwise. ST_BEAT presents one beat and advances on each bus handshake; after the final handshake it moves to ST_DONE. ST_DONE and ST_FAULT each last one cycle and return to ST_IDLE.

Top module: `usplit_top`

## Requirements
- R1: After reset, req_ready is 1 and bus_valid, rsp_done and rsp_fault are 0.
- R2: Beats go in ascending address order. Each beat is the largest naturally aligned unit that fits the bytes still to transfer: a word (bus_size 2, mask 4'b1111) only at lane 0 with at least 4 bytes left, else a halfword (bus_size 1) at an even lane with at least 2 left, else a byte (bus_size 0). bus_strb has one bit set per byte, starting at lane bus_addr[1:0].
- R3: With req_sys_port = 0 (code side), each following beat address keeps bits [31:29] of the previous one and adds the previous beat's byte count to bits [28:0] modulo 2^29.
- R4: With req_sys_port = 1 (system side), each following beat address is the previous one plus the previous beat's byte count, modulo 2^32.
- R5: On a store, request byte k (byte 0 being req_wdata[7:0]) is placed on bus_wdata lane (address of byte k)[1:0] in the beat that covers it; bus_write is 1 on every beat.
- R6: On a load, rsp_done is high for exactly one cycle, the cycle after the final beat handshake. In that cycle rsp_rdata byte k equals the byte read for request byte k, and the bytes at and above the request size are zero.
- R7: A doubleword (req_size 3) is split into two word beats when word aligned. With req_addr[1:0] != 0 it faults and issues no beat.
- R8: A misaligned request (halfword with address bit 0 set, or word with address bits [1:0] nonzero) whose start address lies in 0xE0000000..0xE00FFFFF faults and issues no beat. An aligned request there is carried out normally.
- R9: A faulting request gives a one-cycle rsp_fault pulse in the cycle after acceptance, with bus_valid and rsp_done low, and then returns to idle.
- R10: req_ready is high only in the idle state, and req_valid while busy is ignored; the beats in progress are unchanged.
- R11: While bus_valid is high and bus_ready is low, bus_addr, bus_size, bus_strb and bus_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted on this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr | input | 32 | Byte address of the first byte |
| req_wdata | input | 64 | Store data, right-justified, little-endian |
| req_sys_port | input | 1 | 0 code-side wrap rule, 1 system-side carry rule |
| bus_valid | output | 1 | Beat present |
| bus_ready | input | 1 | Beat accepted / read data valid |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | 32 | Aligned beat address |
| bus_size | output | 2 | Beat size code 0/1/2 |
| bus_strb | output | 4 | Byte-lane mask |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Read data on lanes |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | One-cycle fault pulse |
| rsp_rdata | output | 64 | Merged, zero-extended load result |

## Verification
The bench sweeps every size at every lane offset on both port rules. It covers start addresses just below the top of the code window, of the system window, of the bit-band base area and of the whole address space, plus an ordinary address and two points inside the peripheral window. A design that wrapped on the wrong port, or carried into bit 29 on the code side, would show a wrong second-beat address at those boundaries. A design that chose a halfword at an odd lane, or split a word at lane 2 into bytes, would show a wrong size or mask. The bench stalls the bus on some beats, so that beat values which drift during a stall are caught. It also raises req_valid while a request is in progress, so that a second request accepted too early shows up as corrupted beats. It checks load results byte by byte against an address-derived memory image, which catches misplaced lanes or a wrong merge order.

// File: rtl/usplit_pkg.sv
package usplit_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_DONE,
        ST_FAULT
    } split_state_e;

    localparam int BUS_LANES = 4;
    localparam int REQ_BYTES_MAX = 8;

endpackage

// File: rtl/usplit_beat_plan.sv
module usplit_beat_plan (
    input  logic [1:0] lane_off,
    input  logic [3:0] rem_bytes,
    output logic [2:0] beat_bytes,
    output logic [1:0] beat_size,
    output logic [3:0] beat_strb,
    output logic       beat_last
);
    import usplit_pkg::*;

    logic [4:0] fill;

    always_comb begin
        if (rem_bytes >= 4'd4 && lane_off == 2'd0) begin
            beat_bytes = 3'd4;
            beat_size  = SZ_WORD;
        end else if (rem_bytes >= 4'd2 && !lane_off[0]) begin
            beat_bytes = 3'd2;
            beat_size  = SZ_HALF;
        end else begin
            beat_bytes = 3'd1;
            beat_size  = SZ_BYTE;
        end
        fill      = (5'd1 << beat_bytes) - 5'd1;
        beat_strb = fill[3:0] << lane_off;
        beat_last = ({1'b0, beat_bytes} == rem_bytes);
    end

endmodule

// File: rtl/usplit_addr_step.sv
module usplit_addr_step #(
    parameter int ADDR_W    = 32,
    parameter int WRAP_BITS = 29
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        step,
    input  logic              carry_out,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] linear;

    assign linear = cur + ADDR_W'(step);

    generate
        if (WRAP_BITS >= ADDR_W) begin : g_flat
            assign nxt = linear;
        end else begin : g_window
            logic [WRAP_BITS-1:0] low_next;
            assign low_next = cur[WRAP_BITS-1:0] + WRAP_BITS'(step);
            assign nxt = carry_out ? linear
                                   : {cur[ADDR_W-1:WRAP_BITS], low_next};
        end
    endgenerate

endmodule

// File: rtl/usplit_gather.sv
module usplit_gather (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        capture,
    input  logic [31:0] lane_data,
    input  logic [1:0]  lane_off,
    input  logic [2:0]  nbytes,
    input  logic [2:0]  idx,
    output logic [63:0] merged
);
    logic [31:0] shifted;
    logic [32:0] keep;
    logic [63:0] placed;

    always_comb begin
        shifted = lane_data >> {lane_off, 3'b000};
        keep    = (33'd1 << {nbytes, 3'b000}) - 33'd1;
        placed  = {32'b0, shifted & keep[31:0]} << {idx, 3'b000};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       merged <= '0;
        else if (clear)   merged <= '0;
        else if (capture) merged <= merged | placed;
    end

endmodule

// File: rtl/usplit_top.sv
module usplit_top #(
    parameter int               ADDR_W    = 32,
    parameter int               WRAP_BITS = 29,
    parameter logic [ADDR_W-1:0] PPB_FIRST = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] PPB_LAST  = 32'hE00F_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic              req_sys_port,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [3:0]        bus_strb,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [63:0]       rsp_rdata
);
    import usplit_pkg::*;

    split_state_e      state_q, state_d;
    logic [ADDR_W-1:0] cur_q, nxt_addr;
    logic [3:0]        rem_q, req_bytes;
    logic [2:0]        idx_q;
    logic [63:0]       wsh_q;
    logic              sys_q, write_q;

    logic [2:0] beat_bytes;
    logic [1:0] beat_size;
    logic [3:0] beat_strb;
    logic       beat_last;
    logic       misaligned, in_ppb, req_fault, accept, beat_fire;

    // request screening
    always_comb begin
        req_bytes = 4'd1 << req_size;
        unique case (acc_size_e'(req_size))
            SZ_BYTE:  misaligned = 1'b0;
            SZ_HALF:  misaligned = req_addr[0];
            SZ_WORD:  misaligned = |req_addr[1:0];
            SZ_DWORD: misaligned = |req_addr[1:0];
        endcase
        in_ppb    = (req_addr >= PPB_FIRST) && (req_addr <= PPB_LAST);
        req_fault = misaligned && ((acc_size_e'(req_size) == SZ_DWORD) || in_ppb);
        accept    = req_valid && (state_q == ST_IDLE);
        beat_fire = (state_q == ST_BEAT) && bus_ready;
    end

    usplit_beat_plan u_plan (
        .lane_off  (cur_q[1:0]),
        .rem_bytes (rem_q),
        .beat_bytes(beat_bytes),
        .beat_size (beat_size),
        .beat_strb (beat_strb),
        .beat_last (beat_last)
    );

    usplit_addr_step #(.ADDR_W(ADDR_W), .WRAP_BITS(WRAP_BITS)) u_step (
        .cur      (cur_q),
        .step     (beat_bytes),
        .carry_out(sys_q),
        .nxt      (nxt_addr)
    );

    usplit_gather u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .capture  (beat_fire && !write_q),
        .lane_data(bus_rdata),
        .lane_off (cur_q[1:0]),
        .nbytes   (beat_bytes),
        .idx      (idx_q),
        .merged   (rsp_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_fault ? ST_FAULT : ST_BEAT;
            ST_BEAT:  if (bus_ready && beat_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // beat datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            wsh_q   <= '0;
            sys_q   <= 1'b0;
            write_q <= 1'b0;
        end else if (accept) begin
            cur_q   <= req_addr;
            rem_q   <= req_bytes;
            idx_q   <= '0;
            wsh_q   <= req_wdata;
            sys_q   <= req_sys_port;
            write_q <= req_write;
        end else if (beat_fire) begin
            cur_q <= nxt_addr;
            rem_q <= rem_q - {1'b0, beat_bytes};
            idx_q <= idx_q + beat_bytes;
            wsh_q <= wsh_q >> {beat_bytes, 3'b000};
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        bus_valid = (state_q == ST_BEAT);
        rsp_done  = (state_q == ST_DONE);
        rsp_fault = (state_q == ST_FAULT);
        bus_write = write_q;
        bus_addr  = cur_q;
        bus_size  = beat_size;
        bus_strb  = beat_strb;
        bus_wdata = wsh_q[31:0] << {cur_q[1:0], 3'b000};
    end

    // checks
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_valid && !rsp_done && !rsp_fault));

    assert_beat_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_size != 2'd3) && !(bus_size == 2'd1 && bus_addr[0])
                      && !(bus_size == 2'd2 && bus_addr[1:0] != 2'd0));

    assert_code_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && !beat_last && !sys_q) |=>
            (bus_addr[ADDR_W-1:WRAP_BITS] == $past(bus_addr[ADDR_W-1:WRAP_BITS])));

    assert_sys_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && !beat_last && sys_q) |=>
            (bus_addr == $past(bus_addr) + ADDR_W'($past(beat_bytes))));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (!bus_valid && !rsp_done));

    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |=> (!rsp_fault && req_ready));

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_size)
             && $stable(bus_strb) && $stable(bus_wdata)));

endmodule

// File: tb/usplit_top_tb.sv
module usplit_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'd0;
    logic [63:0] req_wdata = 64'd0;
    logic        req_sys_port = 1'b0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [3:0]  bus_strb;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        rsp_done;
    logic        rsp_fault;
    logic [63:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int run_id = 0;

    always #4 clk = ~clk;

    usplit_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_sys_port(req_sys_port),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_strb(bus_strb),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return a[7:0] ^ {a[12:9], a[30:27]} ^ a[23:16] ^ 8'hA5;
    endfunction

    always_comb begin
        for (int l = 0; l < 4; l++)
            bus_rdata[8*l +: 8] = mem_byte({bus_addr[31:2], 2'(l)});
    end

    function automatic logic [31:0] byte_addr(logic [31:0] a, int k, bit sys);
        logic [28:0] lo;
        lo = a[28:0] + 29'(k);
        return sys ? a + 32'(k) : {a[31:29], lo};
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(bit wr, logic [1:0] sz, logic [31:0] a, bit sys,
                           logic [63:0] wd, bit poke);
        int nbytes, rem, idx, b, beat;
        bit mis, ppb, fault;
        logic [31:0] ea;
        logic [63:0] exp_r;
        logic [31:0] s_addr, s_wdata;
        logic [3:0]  s_strb;
        logic [1:0]  s_size;
        string atag;
        nbytes = 1 << sz;
        mis = (sz == 2'd1 && a[0]) || (sz >= 2'd2 && a[1:0] != 2'd0);
        ppb = (a >= 32'hE000_0000) && (a <= 32'hE00F_FFFF);
        fault = mis && (sz == 2'd3 || ppb);
        atag = sys ? "R4" : "R3";

        @(negedge clk);
        chk("R10", "req_ready idle", 64'(req_ready), 64'd1);
        req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        req_sys_port = sys; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;

        if (fault) begin
            chk((sz == 2'd3) ? "R7" : "R8", "rsp_fault", 64'(rsp_fault), 64'd1);
            chk("R9", "bus_valid on fault", 64'(bus_valid), 64'd0);
            chk("R9", "rsp_done on fault", 64'(rsp_done), 64'd0);
            @(negedge clk);
            chk("R9", "fault pulse end", 64'(rsp_fault), 64'd0);
            chk("R9", "back idle", 64'(req_ready), 64'd1);
            return;
        end

        ea = a; rem = nbytes; idx = 0; beat = 0;
        while (rem > 0) begin
            if (rem >= 4 && ea[1:0] == 2'd0) b = 4;
            else if (rem >= 2 && !ea[0])     b = 2;
            else                             b = 1;
            chk("R2", "bus_valid", 64'(bus_valid), 64'd1);
            chk(atag, "bus_addr", 64'(bus_addr), 64'(ea));
            chk("R2", "bus_size", 64'(bus_size), (b == 4) ? 64'd2 : (b == 2) ? 64'd1 : 64'd0);
            chk("R2", "bus_strb", 64'(bus_strb), 64'((((1 << b) - 1) << ea[1:0]) & 4'hF));
            chk("R5", "bus_write", 64'(bus_write), 64'(wr));
            if (wr) begin
                for (int j = 0; j < b; j++)
                    chk("R5", "lane data", 64'(bus_wdata[8*(ea[1:0]+j) +: 8]),
                        64'(wd[8*(idx+j) +: 8]));
            end
            if (poke && beat == 0) begin
                req_valid = 1'b1;
                req_addr = 32'h0BAD_0000;
                req_size = 2'd2;
                chk("R10", "req_ready busy", 64'(req_ready), 64'd0);
            end
            if ((run_id + beat) % 3 == 1) begin
                s_addr = bus_addr; s_wdata = bus_wdata; s_strb = bus_strb; s_size = bus_size;
                bus_ready = 1'b0;
                @(negedge clk);
                chk("R11", "stall valid", 64'(bus_valid), 64'd1);
                chk("R11", "stall addr", 64'(bus_addr), 64'(s_addr));
                chk("R11", "stall strb", 64'(bus_strb), 64'(s_strb));
                chk("R11", "stall size", 64'(bus_size), 64'(s_size));
                chk("R11", "stall wdata", 64'(bus_wdata), 64'(s_wdata));
            end
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
            req_valid = 1'b0;
            ea = sys ? ea + 32'(b) : {ea[31:29], 29'(ea[28:0] + 29'(b))};
            rem -= b; idx += b; beat++;
            if (beat > 4) begin
                chk("R2", "beat count", 64'(beat), 64'd4);
                rem = 0;
            end
        end

        chk("R6", "rsp_done", 64'(rsp_done), 64'd1);
        chk("R6", "bus idle at done", 64'(bus_valid), 64'd0);
        if (!wr) begin
            exp_r = '0;
            for (int k = 0; k < nbytes; k++)
                exp_r[8*k +: 8] = mem_byte(byte_addr(a, k, sys));
            chk((sz == 2'd3) ? "R7" : "R6", "rsp_rdata", rsp_rdata, exp_r);
        end
        @(negedge clk);
        chk("R6", "done pulse end", 64'(rsp_done), 64'd0);
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [31:0] bases [7];
        bases[0] = 32'h1FFF_FFFC; bases[1] = 32'hDFFF_FFFC; bases[2] = 32'hFFFF_FFFC;
        bases[3] = 32'h21FF_FFFC; bases[4] = 32'h0001_2340; bases[5] = 32'hE000_0100;
        bases[6] = 32'hE00F_FFFC;
        repeat (3) @(negedge clk);
        chk("R1", "req_ready in reset", 64'(req_ready), 64'd1);
        chk("R1", "bus_valid in reset", 64'(bus_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "bus_valid", 64'(bus_valid), 64'd0);
        chk("R1", "rsp_done", 64'(rsp_done), 64'd0);
        chk("R1", "rsp_fault", 64'(rsp_fault), 64'd0);
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 4; s++)
                    for (int o = 0; o < 4; o++)
                        for (int bi = 0; bi < 7; bi++) begin
                            run_req(bit'(w), 2'(s), bases[bi] + 32'(o), bit'(p),
                                    {32'hC0DE_0000 | 32'(run_id), 32'h5EED_0000 ^ 32'(run_id * 7)},
                                    (run_id % 5) == 0);
                            run_id++;
                        end
        finish_up();
    end

endmodule